// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline that has no operand forwarding. Each cycle it takes the two source register numbers of the instruction in decode and compares them with the destination numbers of the three older instructions still in flight (execute, memory and write-back). If a source that the instruction really reads matches a pending destination, the instruction must wait. The block then freezes the program counter and the fetch/decode register and sends a no-op into execute in place of the waiting instruction.

The stall decision is combinational from the current decode inputs and the tracked stage contents. The bubble is written into the execute stage on the next rising clock edge. The block keeps a small three-entry record of in-flight destinations. A stage whose instruction does not write a register records destination 0, so stores and bubbles can never act as producers. Register 0 is never a hazard. A source that the instruction does not use is zeroed before the compare.

Top module: `hzd_stall_unit`

## Requirements
- R1: stall_o is 1 whenever source A is in use, is nonzero, and equals the recorded destination of the execute, memory or write-back stage.
- R2: Source B is tested on its own in the same way, and stall_o is the OR of the two tests.
- R3: A source number of 0 never raises stall_o, even when a stage records a write to register 0.
- R4: A source whose use flag is 0 never raises stall_o, whatever its number.
- R5: pc_we_o and ifid_we_o are both 0 in exactly the cycles where stall_o is 1, and bubble_o equals stall_o.
- R6: After a clock edge taken with stall_o at 1, the execute-stage outputs show destination 0, register write enable 0 and memory write enable 0.
- R7: After a clock edge taken with stall_o at 0, the execute-stage outputs show the decoded memory and register write enables, and the decoded destination when the register write enable is 1 (otherwise 0).
- R8: An instruction with register write enable 0, such as a store, never stalls a later reader of its destination field.
- R9: A reader placed directly behind its producer stalls for 3 cycles. With one instruction between them it stalls 2 cycles, with two between it stalls 1 cycle, and with three or more between it does not stall.
- R10: An active-low reset clears all three recorded stages, so no instruction issued before the reset can stall one issued after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_src_a_i | input | REG_W | Source A register number of the decode instruction |
| dec_use_a_i | input | 1 | Decode instruction reads source A |
| dec_src_b_i | input | REG_W | Source B register number of the decode instruction |
| dec_use_b_i | input | 1 | Decode instruction reads source B |
| dec_dst_i | input | REG_W | Destination register number of the decode instruction |
| dec_reg_we_i | input | 1 | Decode instruction writes a register |
| dec_mem_we_i | input | 1 | Decode instruction writes memory |
| stall_o | output | 1 | Decode instruction must wait |
| pc_we_o | output | 1 | Program counter may update |
| ifid_we_o | output | 1 | Fetch/decode register may update |
| bubble_o | output | 1 | A no-op goes into execute on the next edge |
| ex_dst_o | output | REG_W | Destination recorded in the execute stage |
| ex_reg_we_o | output | 1 | Register write enable of the execute stage |
| ex_mem_we_o | output | 1 | Memory write enable of the execute stage |

## Verification
The bench uses the default REG_W of 3, an eight-register file. At this width every register number, including register 0, can be driven directly, and one short program covers the zero-register and unused-source cases. It places readers at distances one to four behind their producers, which covers every stage a producer passes through and the first distance at which no stall is needed. It also pairs two producers so that each source depends on a different stage. A reference model in the bench follows the three in-flight destinations. A scoreboard compares each cycle's stall controls and execute-stage contents, and the stall count for each reader is checked against the expected distance value.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned DEF_REG_W   = 3;
  localparam int unsigned WATCH_DEPTH = 3;  // execute, memory, write-back
endpackage

// File: rtl/hzd_src_qual.sv
module hzd_src_qual #(
  parameter int unsigned REG_W = hzd_pkg::DEF_REG_W
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             use_i,
  output logic [REG_W-1:0] src_o
);
  // unused operand reads as register 0, which never matches
  assign src_o = use_i ? src_i : '0;
endmodule

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
  parameter int unsigned REG_W = hzd_pkg::DEF_REG_W,
  parameter int unsigned DEPTH = hzd_pkg::WATCH_DEPTH
) (
  input  logic [REG_W-1:0]            src_i,
  input  logic [DEPTH-1:0][REG_W-1:0] dst_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] stage_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    assign stage_hit[g] = (src_i == dst_i[g]);
  end

  assign hit_o = (src_i != '0) && (|stage_hit);
endmodule

// File: rtl/hzd_stage_pipe.sv
module hzd_stage_pipe #(
  parameter int unsigned REG_W = hzd_pkg::DEF_REG_W,
  parameter int unsigned DEPTH = hzd_pkg::WATCH_DEPTH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bubble_i,
  input  logic [REG_W-1:0]            dst_i,
  input  logic                        reg_we_i,
  input  logic                        mem_we_i,
  output logic [DEPTH-1:0][REG_W-1:0] dst_o,
  output logic                        ex_reg_we_o,
  output logic                        ex_mem_we_o
);
  logic [REG_W-1:0] ex_dst_d;
  logic [DEPTH-1:0][REG_W-1:0] dst_q;
  logic ex_reg_we_q, ex_mem_we_q;

  // non-writers enter with destination 0
  assign ex_dst_d = (bubble_i || !reg_we_i) ? '0 : dst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q[0]    <= '0;
      ex_reg_we_q <= 1'b0;
      ex_mem_we_q <= 1'b0;
    end else begin
      dst_q[0]    <= ex_dst_d;
      ex_reg_we_q <= reg_we_i && !bubble_i;
      ex_mem_we_q <= mem_we_i && !bubble_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dst_q[g] <= '0;
      else         dst_q[g] <= dst_q[g-1];
    end
  end

  assign dst_o       = dst_q;
  assign ex_reg_we_o = ex_reg_we_q;
  assign ex_mem_we_o = ex_mem_we_q;
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit #(
  parameter int unsigned REG_W = hzd_pkg::DEF_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] dec_src_a_i,
  input  logic             dec_use_a_i,
  input  logic [REG_W-1:0] dec_src_b_i,
  input  logic             dec_use_b_i,
  input  logic [REG_W-1:0] dec_dst_i,
  input  logic             dec_reg_we_i,
  input  logic             dec_mem_we_i,
  output logic             stall_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o,
  output logic [REG_W-1:0] ex_dst_o,
  output logic             ex_reg_we_o,
  output logic             ex_mem_we_o
);
  localparam int unsigned DEPTH = hzd_pkg::WATCH_DEPTH;

  logic [1:0][REG_W-1:0]       src_q;
  logic [1:0]                  src_hit;
  logic [DEPTH-1:0][REG_W-1:0] stage_dst;
  logic                        stall;

  hzd_src_qual #(.REG_W(REG_W)) u_qual_a (
    .src_i(dec_src_a_i), .use_i(dec_use_a_i), .src_o(src_q[0]));
  hzd_src_qual #(.REG_W(REG_W)) u_qual_b (
    .src_i(dec_src_b_i), .use_i(dec_use_b_i), .src_o(src_q[1]));

  for (genvar s = 0; s < 2; s++) begin : g_src
    hzd_cmp #(.REG_W(REG_W), .DEPTH(DEPTH)) u_cmp (
      .src_i(src_q[s]), .dst_i(stage_dst), .hit_o(src_hit[s]));
  end

  assign stall = |src_hit;

  hzd_stage_pipe #(.REG_W(REG_W), .DEPTH(DEPTH)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bubble_i   (stall),
    .dst_i      (dec_dst_i),
    .reg_we_i   (dec_reg_we_i),
    .mem_we_i   (dec_mem_we_i),
    .dst_o      (stage_dst),
    .ex_reg_we_o(ex_reg_we_o),
    .ex_mem_we_o(ex_mem_we_o)
  );

  assign stall_o   = stall;
  assign pc_we_o   = !stall;
  assign ifid_we_o = !stall;
  assign bubble_o  = stall;
  assign ex_dst_o  = stage_dst[0];
endmodule

// File: rtl/hzd_stall_unit_chk.sv
module hzd_stall_unit_chk #(
  parameter int unsigned REG_W = hzd_pkg::DEF_REG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] dec_src_a_i,
  input logic             dec_use_a_i,
  input logic [REG_W-1:0] dec_src_b_i,
  input logic             dec_use_b_i,
  input logic             stall_o,
  input logic             pc_we_o,
  input logic             ifid_we_o,
  input logic             bubble_o,
  input logic [REG_W-1:0] ex_dst_o,
  input logic             ex_reg_we_o,
  input logic             ex_mem_we_o
);
  assert_src_a_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_use_a_i && dec_src_a_i != '0 && dec_src_a_i == ex_dst_o) |-> stall_o);

  assert_src_b_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_use_b_i && dec_src_b_i != '0 && dec_src_b_i == ex_dst_o) |-> stall_o);

  assert_zero_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_src_a_i == '0 && dec_src_b_i == '0) |-> !stall_o);

  assert_unused_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_use_a_i && !dec_use_b_i) |-> !stall_o);

  assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o == !pc_we_o) && (stall_o == !ifid_we_o) && (bubble_o == stall_o));

  assert_bubble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (ex_dst_o == '0 && !ex_reg_we_o && !ex_mem_we_o));

  assert_nonwriter_dst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_o != '0) |-> ex_reg_we_o);
endmodule

bind hzd_stall_unit hzd_stall_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dec_src_a_i(dec_src_a_i),
  .dec_use_a_i(dec_use_a_i),
  .dec_src_b_i(dec_src_b_i),
  .dec_use_b_i(dec_use_b_i),
  .stall_o    (stall_o),
  .pc_we_o    (pc_we_o),
  .ifid_we_o  (ifid_we_o),
  .bubble_o   (bubble_o),
  .ex_dst_o   (ex_dst_o),
  .ex_reg_we_o(ex_reg_we_o),
  .ex_mem_we_o(ex_mem_we_o)
);

// File: tb/hzd_stall_unit_bench.sv
module hzd_stall_unit_bench;
  localparam int unsigned REG_W = 3;

  typedef struct {
    logic             stall;
    logic [REG_W-1:0] ex_dst;
    logic             ex_rwe;
    logic             ex_mwe;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [REG_W-1:0] src_a = '0, src_b = '0, dst = '0;
  logic use_a = 1'b0, use_b = 1'b0, rwe = 1'b0, mwe = 1'b0;
  logic stall, pc_we, ifid_we, bubble, ex_rwe, ex_mwe;
  logic [REG_W-1:0] ex_dst;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];

  // bench model of the three in-flight destinations
  logic [REG_W-1:0] m_dst [3];
  logic m_rwe, m_mwe;

  always #4 clk = ~clk;

  hzd_stall_unit #(.REG_W(REG_W)) u_hzd_stall_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .dec_src_a_i(src_a), .dec_use_a_i(use_a),
    .dec_src_b_i(src_b), .dec_use_b_i(use_b),
    .dec_dst_i(dst), .dec_reg_we_i(rwe), .dec_mem_we_i(mwe),
    .stall_o(stall), .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble),
    .ex_dst_o(ex_dst), .ex_reg_we_o(ex_rwe), .ex_mem_we_o(ex_mwe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per cycle, away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " R1 R2 stall"}, int'(stall), int'(e.stall));
      chk({e.tag, " R5 pc_we"}, int'(pc_we), int'(!e.stall));
      chk({e.tag, " R5 ifid_we"}, int'(ifid_we), int'(!e.stall));
      chk({e.tag, " R5 bubble"}, int'(bubble), int'(e.stall));
      chk({e.tag, " R6 R7 ex_dst"}, int'(ex_dst), int'(e.ex_dst));
      chk({e.tag, " R6 R7 ex_rwe"}, int'(ex_rwe), int'(e.ex_rwe));
      chk({e.tag, " R6 R7 ex_mwe"}, int'(ex_mwe), int'(e.ex_mwe));
    end
  end

  function automatic logic src_hits(input logic [REG_W-1:0] s, input logic u);
    return u && (s != '0) && (s == m_dst[0] || s == m_dst[1] || s == m_dst[2]);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) m_dst[i] = '0;
    m_rwe = 1'b0;
    m_mwe = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    src_a = '0; src_b = '0; dst = '0;
    use_a = 0; use_b = 0; rwe = 0; mwe = 0;
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  // driver: hold one decode instruction until it leaves decode
  task automatic issue(input string tag,
                       input logic [REG_W-1:0] a, input logic ua,
                       input logic [REG_W-1:0] b, input logic ub,
                       input logic [REG_W-1:0] d, input logic rw, input logic mw,
                       output int n_stall);
    logic st;
    exp_t e;
    n_stall = 0;
    do begin
      @(posedge clk);
      #1;
      src_a = a; use_a = ua; src_b = b; use_b = ub;
      dst = d; rwe = rw; mwe = mw;
      st = src_hits(a, ua) || src_hits(b, ub);
      e.stall = st; e.ex_dst = m_dst[0]; e.ex_rwe = m_rwe; e.ex_mwe = m_mwe;
      e.tag = tag;
      sb.push_back(e);
      if (st) n_stall++;
      m_dst[2] = m_dst[1];
      m_dst[1] = m_dst[0];
      m_dst[0] = (st || !rw) ? '0 : d;
      m_rwe = rw && !st;
      m_mwe = mw && !st;
    end while (st);
  endtask

  task automatic nop();
    int n;
    issue("nop", '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, n);
  endtask

  task automatic drain();
    @(posedge clk);
    #1;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n;
    model_clear();
    // reset state, R10
    src_a = 3'd0; use_a = 1'b1;
    @(negedge clk);
    chk("R10 reset stall", int'(stall), 0);
    chk("R10 reset ex_dst", int'(ex_dst), 0);
    chk("R10 reset ex_rwe", int'(ex_rwe), 0);
    do_reset();

    // R9 R1: reader directly behind producer
    issue("R9 prod", 3'd1, 1, 3'd2, 1, 3'd3, 1, 0, n);
    issue("R9 d1", 3'd3, 1, 3'd0, 0, 3'd5, 1, 0, n);
    chk("R9 R1 distance1 stalls", n, 3);

    // R2 R9: distance 2 on source B
    issue("R9 prod", 3'd0, 0, 3'd0, 0, 3'd6, 1, 0, n);
    nop();
    issue("R2 d2", 3'd1, 1, 3'd6, 1, 3'd2, 1, 0, n);
    chk("R9 R2 distance2 stalls", n, 2);

    // R9 distance 3 and 4
    issue("R9 prod", 3'd0, 0, 3'd0, 0, 3'd7, 1, 0, n);
    nop(); nop();
    issue("R9 d3", 3'd7, 1, 3'd0, 0, 3'd0, 0, 0, n);
    chk("R9 distance3 stalls", n, 1);
    issue("R9 prod", 3'd0, 0, 3'd0, 0, 3'd4, 1, 0, n);
    nop(); nop(); nop();
    issue("R9 d4", 3'd4, 1, 3'd4, 1, 3'd1, 1, 0, n);
    chk("R9 distance4 stalls", n, 0);

    // R3: write to register 0 never a producer for source 0
    issue("R3 prod", 3'd0, 0, 3'd0, 0, 3'd0, 1, 0, n);
    issue("R3 rd0", 3'd0, 1, 3'd0, 1, 3'd1, 1, 0, n);
    chk("R3 zero source stalls", n, 0);

    // R4: unused source
    issue("R4 prod", 3'd0, 0, 3'd0, 0, 3'd5, 1, 0, n);
    issue("R4 unused", 3'd5, 0, 3'd5, 0, 3'd2, 1, 0, n);
    chk("R4 unused source stalls", n, 0);

    // R8: store does not produce; memory enable passes to execute (R7)
    issue("R8 store", 3'd1, 1, 3'd6, 1, 3'd6, 0, 1, n);
    issue("R8 rd6", 3'd6, 1, 3'd6, 1, 3'd3, 1, 0, n);
    chk("R8 store reader stalls", n, 0);
    nop(); nop(); nop();

    // R1 R2: sources depend on different stages
    issue("R2 p1", 3'd0, 0, 3'd0, 0, 3'd1, 1, 0, n);
    issue("R2 p2", 3'd0, 0, 3'd0, 0, 3'd2, 1, 0, n);
    issue("R2 both", 3'd1, 1, 3'd2, 1, 3'd3, 1, 0, n);
    chk("R2 two-source stalls", n, 3);

    // R10: reset drops in-flight producer
    issue("R10 prod", 3'd0, 0, 3'd0, 0, 3'd7, 1, 0, n);
    drain();
    do_reset();
    issue("R10 after", 3'd7, 1, 3'd7, 1, 3'd0, 0, 0, n);
    chk("R10 post-reset stalls", n, 0);

    drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule